// File: doc/BRIEF.md
# Debug Port Control/Status Register

This block holds the one control/status byte of a single-wire debug link. Only the debug side can change or see it. A debug-side write updates the control fields, each under its own rule. A read returns the stored fields together with two status bits that the core hardware owns. The system bus has a port into the block, but the block discards every system-bus write and always presents zero to system-bus reads.

The stored fields drive the side-band controls used elsewhere in the chip:
- masking of the internal reset sources,
- enabling of full-memory debug access,
- the active link speed,
- an oscillator-off request for halt,
- a CPU stall request,
- a one-clock system reset request.

A soft-reset command acts only when both the debug-module field and the reset-enable field are set. When it acts, it clears the register, returns the link to its off state and raises that reset request.

All state uses a synchronous active-low power-on reset. Strobes are one clock wide and are sampled on the rising edge.

Top module: `dbg_csr`

## Requirements
- R1: While `rst_n` is low at a clock edge, every stored field is cleared. After that edge, `dbg_rdata` reads 00h when no core status input is high, `iface_off` is 1, and every control output is 0.
- R2: A system-bus write (`sys_wr_en`) changes no field, and `sys_rdata` is always 00h.
- R3: A debug write stores bit 7 (reset mask), bit 3 (oscillator off), bit 2 (soft-reset enable) and bit 0 (priority). From the next cycle, `rst_mask`, `osc_off_req` and `cpu_stall_req` follow bits 7, 3 and 0.
- R4: Bit 5 (debug module) can only be set by a debug write; writing 0 leaves it unchanged. `mem_access_en` is bit 5 AND NOT bit 6.
- R5: Bit 6 reads the live OR of `core_halt`, `core_wfi` and `core_rdp` in the same cycle. Writes to bit 6 are ignored.
- R6: Bit 1 (clock trimmed) becomes 1 in the cycle after `core_trimmed` is high and then stays 1. It returns to 0 in the cycle after `ext_rst` is high; `ext_rst` wins over `core_trimmed`. Writes to bit 1 are ignored.
- R7: A debug write updates bit 4 (speed request) only while bit 1 is 1. Otherwise bit 4 keeps its value.
- R8: At each edge where `link_idle` is high, `speed_hi` takes the value of bit 4. At other edges it holds its value. `speed_hi` is 0 whenever bit 1 is 0.
- R9: `comm_rst` clears bit 4 and `speed_hi` in the next cycle. It takes priority over a debug write in the same cycle.
- R10: `srst_cmd` with bit 5 = 1 and bit 2 = 1 has the following effect in the next cycle: `sys_rst_req` is high for exactly one cycle, all stored bits including bit 1 are cleared, a simultaneous write is dropped, and `iface_off` is 1. With either bit at 0, `srst_cmd` has no effect.
- R11: A debug write clears `iface_off` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| ext_rst | input | 1 | External reset strobe; clears the trimmed flag |
| srst_cmd | input | 1 | Soft-reset command strobe from the link |
| comm_rst | input | 1 | Communication-reset strobe |
| link_idle | input | 1 | Link is idle; a speed change may take effect |
| core_halt | input | 1 | Core is halted |
| core_wfi | input | 1 | Core is waiting for an interrupt |
| core_rdp | input | 1 | Readout protection is active |
| core_trimmed | input | 1 | Core configuration reports a trimmed clock |
| dbg_wr_en | input | 1 | Debug-side write strobe |
| dbg_wdata | input | 8 | Debug-side write data |
| dbg_rdata | output | 8 | Debug-side read value |
| sys_wr_en | input | 1 | System-bus write attempt |
| sys_wdata | input | 8 | System-bus write data (discarded) |
| sys_rdata | output | 8 | System-bus read value, always zero |
| rst_mask | output | 1 | Mask internal reset sources |
| mem_access_en | output | 1 | Full memory access allowed over the link |
| speed_hi | output | 1 | Active bit format is high speed |
| osc_off_req | output | 1 | Drop the oscillator-on request in halt |
| cpu_stall_req | output | 1 | Stall the CPU for debug priority |
| sys_rst_req | output | 1 | One-cycle system reset request |
| iface_off | output | 1 | Link interface is in its off state |

## Verification
Every stored field is visible on `dbg_rdata` in the cycle after the edge that changes it. A wrong write rule, a lost sticky bit or a spurious clear therefore shows at the next sample. The sweeps read back all 256 write values with the trimmed flag both clear and set, so a misplaced bit position is exposed within one write.

The speed state is hidden behind `speed_hi`. It is checked across idle and busy edges and across losses of the trimmed flag, so a speed change outside idle appears one cycle after the offending edge. A soft reset that is gated wrongly shows at once, in the next cycle, as a missing or extra `sys_rst_req` pulse and a read value that is not cleared.

// File: rtl/dcsr_pkg.sv
// Shared constants for the debug control/status register.
// Assumes an 8-bit register. The bit positions are fixed because the link
// engine and the debug host decode them.
package dcsr_pkg;
    localparam int REG_W  = 8;
    localparam int B_SAFE = 7;
    localparam int B_NOAC = 6;
    localparam int B_DM   = 5;
    localparam int B_HS   = 4;
    localparam int B_OSC  = 3;
    localparam int B_RSTE = 2;
    localparam int B_TRIM = 1;
    localparam int B_PRI  = 0;
endpackage

// File: rtl/dcsr_ctrl_bits.sv
// Holds the plain writable control fields, the set-only debug-module field,
// the link off flag and the one-cycle system reset pulse.
// Assumes srst_fire_i is already qualified by the debug-module and
// reset-enable fields, and that it outranks a write in the same cycle.
module dcsr_ctrl_bits
    import dcsr_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en_i,
    input  logic [W-1:0] wdata_i,
    input  logic         srst_fire_i,
    output logic         safe_o,
    output logic         dm_o,
    output logic         osc_o,
    output logic         rste_o,
    output logic         pri_o,
    output logic         off_o,
    output logic         rst_pulse_o
);
    // Register update: power-on reset, qualified soft reset, then debug write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            safe_o      <= 1'b0;
            dm_o        <= 1'b0;
            osc_o       <= 1'b0;
            rste_o      <= 1'b0;
            pri_o       <= 1'b0;
            off_o       <= 1'b1;
            rst_pulse_o <= 1'b0;
        end else if (srst_fire_i) begin
            safe_o      <= 1'b0;
            dm_o        <= 1'b0;
            osc_o       <= 1'b0;
            rste_o      <= 1'b0;
            pri_o       <= 1'b0;
            off_o       <= 1'b1;
            rst_pulse_o <= 1'b1;
        end else begin
            rst_pulse_o <= 1'b0;
            if (wr_en_i) begin
                safe_o <= wdata_i[B_SAFE];
                dm_o   <= dm_o | wdata_i[B_DM];
                osc_o  <= wdata_i[B_OSC];
                rste_o <= wdata_i[B_RSTE];
                pri_o  <= wdata_i[B_PRI];
                off_o  <= 1'b0;
            end
        end
    end

    a_r10_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pulse_o |=> !rst_pulse_o);

    a_r4_dm_set_only: assert property (@(posedge clk) disable iff (!rst_n)
        dm_o && !srst_fire_i |=> dm_o);

    a_r11_write_wakes: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i && !srst_fire_i |=> !off_o);
endmodule

// File: rtl/dcsr_status.sv
// Tracks the hardware-owned status bits: the sticky clock-trimmed flag and
// the live bus-not-accessible indication.
// Assumes the core status inputs are synchronous to clk.
module dcsr_status (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic ext_rst_i,
    input  logic trimmed_i,
    input  logic halt_i,
    input  logic wfi_i,
    input  logic rdp_i,
    output logic trim_o,
    output logic noacc_o
);
    // Sticky trimmed flag: cleared by any reset source, set by the core flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trim_o <= 1'b0;
        end else if (clr_i || ext_rst_i) begin
            trim_o <= 1'b0;
        end else if (trimmed_i) begin
            trim_o <= 1'b1;
        end
    end

    // Live bus-blocked status, no storage.
    always_comb noacc_o = halt_i | wfi_i | rdp_i;

    a_r6_ext_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ext_rst_i |=> !trim_o);

    a_r6_trim_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        trim_o && !ext_rst_i && !clr_i |=> trim_o);
endmodule

// File: rtl/dcsr_speed.sv
// Holds the requested speed bit and the active speed state. A request is
// accepted only while the clock is trimmed. The active state follows the
// request only at idle edges.
// Assumes clr_i already merges the communication reset and a qualified
// soft reset.
module dcsr_speed (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic wr_en_i,
    input  logic wr_hs_i,
    input  logic trim_i,
    input  logic idle_i,
    output logic hs_req_o,
    output logic speed_hi_o
);
    logic spd_q;

    // Requested speed: cleared by reset sources, written only when trimmed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_req_o <= 1'b0;
        end else if (clr_i) begin
            hs_req_o <= 1'b0;
        end else if (wr_en_i && trim_i) begin
            hs_req_o <= wr_hs_i;
        end
    end

    // Active speed: forced low when untrimmed, updated only at idle edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spd_q <= 1'b0;
        end else if (clr_i || !trim_i) begin
            spd_q <= 1'b0;
        end else if (idle_i) begin
            spd_q <= hs_req_o;
        end
    end

    // Output gating so that the loss of the trimmed flag shows at once.
    always_comb speed_hi_o = spd_q & trim_i;

    a_r7_hs_locked: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i && !trim_i && !clr_i |=> $stable(hs_req_o));

    a_r8_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !idle_i && !clr_i && trim_i |=> $stable(spd_q));

    a_r9_clear_speed: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !hs_req_o && !speed_hi_o);
endmodule

// File: rtl/dbg_csr.sv
// Top of the debug control/status register. It qualifies the soft reset,
// merges the clear sources, assembles the read value and drives the
// side-band controls. System-bus writes are discarded and system-bus reads
// return zero.
// Assumes all strobes are one clock wide and synchronous to clk.
module dbg_csr
    import dcsr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_rst,
    input  logic             srst_cmd,
    input  logic             comm_rst,
    input  logic             link_idle,
    input  logic             core_halt,
    input  logic             core_wfi,
    input  logic             core_rdp,
    input  logic             core_trimmed,
    input  logic             dbg_wr_en,
    input  logic [REG_W-1:0] dbg_wdata,
    output logic [REG_W-1:0] dbg_rdata,
    input  logic             sys_wr_en,
    input  logic [REG_W-1:0] sys_wdata,
    output logic [REG_W-1:0] sys_rdata,
    output logic             rst_mask,
    output logic             mem_access_en,
    output logic             speed_hi,
    output logic             osc_off_req,
    output logic             cpu_stall_req,
    output logic             sys_rst_req,
    output logic             iface_off
);
    logic safe_q, dm_q, osc_q, rste_q, pri_q;
    logic trim_q, noacc;
    logic hs_req_q;
    logic srst_fire;

    // Soft reset acts only with both enabling fields set.
    always_comb srst_fire = srst_cmd & dm_q & rste_q;

    dcsr_ctrl_bits #(.W(REG_W)) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (dbg_wr_en),
        .wdata_i     (dbg_wdata),
        .srst_fire_i (srst_fire),
        .safe_o      (safe_q),
        .dm_o        (dm_q),
        .osc_o       (osc_q),
        .rste_o      (rste_q),
        .pri_o       (pri_q),
        .off_o       (iface_off),
        .rst_pulse_o (sys_rst_req)
    );

    dcsr_status stat_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (srst_fire),
        .ext_rst_i (ext_rst),
        .trimmed_i (core_trimmed),
        .halt_i    (core_halt),
        .wfi_i     (core_wfi),
        .rdp_i     (core_rdp),
        .trim_o    (trim_q),
        .noacc_o   (noacc)
    );

    dcsr_speed spd_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (srst_fire | comm_rst),
        .wr_en_i    (dbg_wr_en),
        .wr_hs_i    (dbg_wdata[B_HS]),
        .trim_i     (trim_q),
        .idle_i     (link_idle),
        .hs_req_o   (hs_req_q),
        .speed_hi_o (speed_hi)
    );

    // Read value assembly at the positions the host decodes.
    always_comb begin
        dbg_rdata         = '0;
        dbg_rdata[B_SAFE] = safe_q;
        dbg_rdata[B_NOAC] = noacc;
        dbg_rdata[B_DM]   = dm_q;
        dbg_rdata[B_HS]   = hs_req_q;
        dbg_rdata[B_OSC]  = osc_q;
        dbg_rdata[B_RSTE] = rste_q;
        dbg_rdata[B_TRIM] = trim_q;
        dbg_rdata[B_PRI]  = pri_q;
    end

    // Side-band controls and the closed system-bus view.
    always_comb begin
        sys_rdata     = '0;
        rst_mask      = safe_q;
        mem_access_en = dm_q & ~noacc;
        osc_off_req   = osc_q;
        cpu_stall_req = pri_q;
    end

    a_r2_sys_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        sys_wr_en && (sys_wdata != '0) && !dbg_wr_en && !srst_fire
        |=> $stable({safe_q, dm_q, osc_q, rste_q, pri_q}));

    a_r10_gated_reset: assert property (@(posedge clk) disable iff (!rst_n)
        srst_cmd && !(dm_q && rste_q) |=> !sys_rst_req);
endmodule

// File: tb/dbg_csr_tb_top.sv
// Self-checking bench for dbg_csr: sweeps all write values under both
// states of the trimmed flag, and walks the status, speed and reset rules.
module dbg_csr_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_rst = 1'b0, srst_cmd = 1'b0, comm_rst = 1'b0, link_idle = 1'b0;
    logic       core_halt = 1'b0, core_wfi = 1'b0, core_rdp = 1'b0, core_trimmed = 1'b0;
    logic       dbg_wr_en = 1'b0, sys_wr_en = 1'b0;
    logic [7:0] dbg_wdata = '0, sys_wdata = '0;
    logic [7:0] dbg_rdata, sys_rdata;
    logic       rst_mask, mem_access_en, speed_hi, osc_off_req, cpu_stall_req;
    logic       sys_rst_req, iface_off;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0] e_ctl;
    logic       e_trim;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dbg_csr dut_i (
        .clk(clk), .rst_n(rst_n), .ext_rst(ext_rst), .srst_cmd(srst_cmd),
        .comm_rst(comm_rst), .link_idle(link_idle), .core_halt(core_halt),
        .core_wfi(core_wfi), .core_rdp(core_rdp), .core_trimmed(core_trimmed),
        .dbg_wr_en(dbg_wr_en), .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata),
        .sys_wr_en(sys_wr_en), .sys_wdata(sys_wdata), .sys_rdata(sys_rdata),
        .rst_mask(rst_mask), .mem_access_en(mem_access_en), .speed_hi(speed_hi),
        .osc_off_req(osc_off_req), .cpu_stall_req(cpu_stall_req),
        .sys_rst_req(sys_rst_req), .iface_off(iface_off)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] v);
        dbg_wr_en = 1'b1;
        dbg_wdata = v;
        tick();
        dbg_wr_en = 1'b0;
    endtask

    function automatic logic [7:0] exp_rd();
        logic [7:0] r;
        r    = e_ctl;
        r[1] = e_trim;
        r[6] = core_halt | core_wfi | core_rdp;
        return r;
    endfunction

    // Apply a write to the expected image (debug module set-only, speed gated).
    task automatic model_wr(input logic [7:0] v);
        e_ctl[7] = v[7];
        e_ctl[3] = v[3];
        e_ctl[2] = v[2];
        e_ctl[0] = v[0];
        e_ctl[5] = e_ctl[5] | v[5];
        if (e_trim) e_ctl[4] = v[4];
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        tick();
        tick();
        chk("R1 rdata", dbg_rdata, 8'h00);
        chk("R1 iface_off", {7'd0, iface_off}, 8'd1);
        chk("R1 controls", {3'd0, rst_mask, mem_access_en, speed_hi, cpu_stall_req, sys_rst_req}, 8'd0);
        rst_n  = 1'b1;
        e_ctl  = 8'h00;
        e_trim = 1'b0;

        // R3 R4 R7 R11: write sweep with the trimmed flag clear
        for (int v = 0; v < 256; v++) begin
            wr(v[7:0]);
            model_wr(v[7:0]);
            chk("R3 rdata", dbg_rdata, exp_rd());
            chk("R3 rst_mask", {7'd0, rst_mask}, {7'd0, v[7]});
            chk("R3 osc_off_req", {7'd0, osc_off_req}, {7'd0, v[3]});
            chk("R3 cpu_stall_req", {7'd0, cpu_stall_req}, {7'd0, v[0]});
            chk("R4 mem_access_en", {7'd0, mem_access_en}, {7'd0, e_ctl[5]});
            chk("R7 hs rejected", {7'd0, dbg_rdata[4]}, 8'd0);
            chk("R11 iface_off", {7'd0, iface_off}, 8'd0);
        end

        // R6 trimmed flag set and sticky
        core_trimmed = 1'b1;
        tick();
        core_trimmed = 1'b0;
        e_trim = 1'b1;
        chk("R6 set", dbg_rdata, exp_rd());
        tick();
        chk("R6 sticky", dbg_rdata, exp_rd());

        // R7 R8: sweep with trimmed flag set, link busy
        for (int v = 0; v < 256; v++) begin
            wr(v[7:0]);
            model_wr(v[7:0]);
            chk("R7 rdata", dbg_rdata, exp_rd());
            chk("R8 hold busy", {7'd0, speed_hi}, 8'd0);
        end
        link_idle = 1'b1;
        tick();
        link_idle = 1'b0;
        chk("R8 idle take", {7'd0, speed_hi}, 8'd1);
        wr(8'h00);
        model_wr(8'h00);
        chk("R8 hold after write", {7'd0, speed_hi}, 8'd1);
        link_idle = 1'b1;
        tick();
        link_idle = 1'b0;
        chk("R8 idle drop", {7'd0, speed_hi}, 8'd0);

        // R9 communication reset
        wr(8'h10);
        model_wr(8'h10);
        link_idle = 1'b1;
        tick();
        link_idle = 1'b0;
        chk("R9 speed up", {7'd0, speed_hi}, 8'd1);
        comm_rst = 1'b1;
        tick();
        comm_rst = 1'b0;
        e_ctl[4] = 1'b0;
        chk("R9 rdata", dbg_rdata, exp_rd());
        chk("R9 speed", {7'd0, speed_hi}, 8'd0);
        comm_rst = 1'b1;
        wr(8'h10);
        comm_rst = 1'b0;
        model_wr(8'h10);
        e_ctl[4] = 1'b0;
        chk("R9 beats write", dbg_rdata, exp_rd());

        // R6 R7 R8: external reset drops trim, speed, and write gating
        wr(8'h10);
        model_wr(8'h10);
        link_idle = 1'b1;
        tick();
        link_idle = 1'b0;
        chk("R8 speed up", {7'd0, speed_hi}, 8'd1);
        ext_rst = 1'b1;
        tick();
        ext_rst = 1'b0;
        e_trim = 1'b0;
        chk("R6 ext clear", dbg_rdata, exp_rd());
        chk("R8 untrimmed low", {7'd0, speed_hi}, 8'd0);
        wr(8'h00);
        model_wr(8'h00);
        chk("R7 hs kept", dbg_rdata, exp_rd());
        link_idle = 1'b1;
        tick();
        link_idle = 1'b0;
        chk("R8 untrimmed idle", {7'd0, speed_hi}, 8'd0);
        ext_rst = 1'b1;
        core_trimmed = 1'b1;
        tick();
        ext_rst = 1'b0;
        core_trimmed = 1'b0;
        chk("R6 ext wins", {7'd0, dbg_rdata[1]}, 8'd0);

        // R5 live bus status over all input combinations
        for (int s = 0; s < 8; s++) begin
            core_halt = s[0];
            core_wfi  = s[1];
            core_rdp  = s[2];
            #1;
            chk("R5 noacc", {7'd0, dbg_rdata[6]}, {7'd0, (s != 0)});
            chk("R4 access gate", {7'd0, mem_access_en}, {7'd0, e_ctl[5] & (s == 0)});
        end
        core_halt = 1'b0;
        core_wfi  = 1'b0;
        core_rdp  = 1'b0;
        wr(8'h40);
        model_wr(8'h40);
        chk("R5 write ignored", dbg_rdata, exp_rd());

        // R2 system-bus sweep
        for (int v = 0; v < 256; v++) begin
            sys_wr_en = 1'b1;
            sys_wdata = v[7:0];
            tick();
            chk("R2 rdata", dbg_rdata, exp_rd());
            chk("R2 sys_rdata", sys_rdata, 8'h00);
        end
        sys_wr_en = 1'b0;

        // R10 soft reset gating
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        e_ctl = 8'h00;
        e_trim = 1'b0;
        chk("R1 re-reset", dbg_rdata, 8'h00);
        wr(8'h04);
        model_wr(8'h04);
        srst_cmd = 1'b1;
        tick();
        srst_cmd = 1'b0;
        chk("R10 no dm pulse", {7'd0, sys_rst_req}, 8'd0);
        chk("R10 no dm rdata", dbg_rdata, exp_rd());
        wr(8'h20);
        model_wr(8'h20);
        srst_cmd = 1'b1;
        tick();
        srst_cmd = 1'b0;
        chk("R10 no rste pulse", {7'd0, sys_rst_req}, 8'd0);
        chk("R10 no rste rdata", dbg_rdata, exp_rd());
        core_trimmed = 1'b1;
        wr(8'h25);
        core_trimmed = 1'b0;
        model_wr(8'h25);
        e_trim = 1'b1;
        chk("R10 armed", dbg_rdata, exp_rd());
        srst_cmd  = 1'b1;
        wr(8'hFF);
        srst_cmd  = 1'b0;
        chk("R10 pulse", {7'd0, sys_rst_req}, 8'd1);
        chk("R10 cleared", dbg_rdata, 8'h00);
        chk("R10 off", {7'd0, iface_off}, 8'd1);
        chk("R10 controls", {6'd0, cpu_stall_req, mem_access_en}, 8'd0);
        tick();
        chk("R10 one cycle", {7'd0, sys_rst_req}, 8'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule